// File: doc/BRIEF.md
# Prescaled Timer Pair

Two general-purpose counters share one clock, one free-running clock divider and one debug-halt input. Each counter takes a 16-bit control word, a reload value and a load strobe. The control word selects the count source: the core clock, a power-of-two division of it, or the rising edges of an external event input. It also selects a qualifying mode (free, gated by an external level, or chained), the direction, a 16- or 32-bit width, automatic reload, interrupt enable, and whether the debug-halt input freezes counting.

A counter that reaches its terminal count raises a sticky status flag. It then either takes the reload value again or parks at the terminal count. When the upper counter is chained, it advances once for each terminal-count hit of the lower counter. Reading the two counts as {upper, lower} then gives one wider count.

The control words are held at the ports as register-level values. A status flag is cleared by holding the clear bit of its control word high.

Top module: `tmr_pair`

## Requirements
- R1: While control bit 15 of a timer is 0, its count does not change, except through the load strobe.
- R2: A pulse on `ld_i[i]` replaces the count of timer i with its reload value on the next clock edge, taking priority over counting. When control bit 1 is 0, the value loaded is masked to its low 16 bits.
- R3: Control bits 8:6 equal to k, with k from 0 to 6, make the timer step once every 2^k clock cycles. The steps come from one free-running divider.
- R4: Control bits 8:6 equal to 7 make the timer step once per rising edge of `ext_evt_i[i]`, taken after a two-flop synchronizer.
- R5: Control bits 5:4 choose the mode. In mode 0 every source step counts. In mode 1 a step counts only while the synchronized `ext_gate_i[i]` is low. In mode 2 a step counts only while it is high.
- R6: Control bit 2 set to 0 counts up and set to 1 counts down. Control bit 1 set to 0 gives a 16-bit counter and set to 1 gives a 32-bit counter. The terminal count is 0 when counting down and the all-ones value of the width when counting up.
- R7: A step that makes the count equal the terminal count sets the timer's flag. If control bit 0 is 1, the counter takes the reload value in place of the terminal count. If it is 0, the counter stays at the terminal count and ignores further steps.
- R8: A flag stays set until its control bit 9 is 1. Bit 9 clears the flag, but a terminal-count hit in the same cycle wins. `irq_o[i]` equals the flag ANDed with control bit 3.
- R9: While control bit 10 is 1 and `dbg_halt_i` is 1, the timer does not step. While control bit 10 is 0, `dbg_halt_i` has no effect.
- R10: With control bits 5:4 equal to 3, timer 1 steps exactly once in each cycle in which timer 0 hits its terminal count, and its own clock source is ignored.
- R11: Timer 0 treats mode 3 as mode 0.
- R12: After reset both counts and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl0_i | input | 16 | Control word of timer 0 |
| ctl1_i | input | 16 | Control word of timer 1 |
| rld0_i | input | CNT_W | Reload value of timer 0 |
| rld1_i | input | CNT_W | Reload value of timer 1 |
| ld_i | input | 2 | Load strobe per timer |
| ext_evt_i | input | 2 | Asynchronous event input per timer |
| ext_gate_i | input | 2 | Asynchronous gate level per timer |
| dbg_halt_i | input | 1 | Debug-halt request |
| cnt0_o | output | CNT_W | Current count of timer 0 |
| cnt1_o | output | CNT_W | Current count of timer 1 |
| flag_o | output | 2 | Sticky terminal-count status per timer |
| irq_o | output | 2 | Interrupt request per timer |

## Verification
The properties assume that `ld_i` and the control words are treated as register values. They also assume that a load strobe lasts one cycle, and that a count may change in a cycle only when that cycle offered a qualified step or a load. The event and gate inputs may be asynchronous, and the properties check the synchronized copies only. The stimulus changes every input on the falling clock edge. It holds a gate level for several cycles before a timer is enabled, and spaces event edges at least two cycles apart so that each edge survives the synchronizer as one step.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int CTL_W   = 16;
   localparam int B_EN    = 15;
   localparam int B_DBG   = 10;
   localparam int B_CLR   = 9;
   localparam int B_SELHI = 8;
   localparam int B_SELLO = 6;
   localparam int B_MODHI = 5;
   localparam int B_MODLO = 4;
   localparam int B_IE    = 3;
   localparam int B_DOWN  = 2;
   localparam int B_WIDE  = 1;
   localparam int B_RLD   = 0;
   localparam int SEL_W   = B_SELHI - B_SELLO + 1;
   localparam int SEL_EXT = (1 << SEL_W) - 1;

   typedef enum logic [1:0] {
      M_FREE    = 2'd0,
      M_GATE_LO = 2'd1,
      M_GATE_HI = 2'd2,
      M_CHAIN   = 2'd3
   } mode_e;

   typedef struct packed {
      logic             en;
      logic             dbg_stop;
      logic             clr;
      logic [SEL_W-1:0] sel;
      mode_e            mode;
      logic             ie;
      logic             down;
      logic             wide;
      logic             rld;
   } ctl_t;

   function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] w);
      ctl_t c;
      c.en       = w[B_EN];
      c.dbg_stop = w[B_DBG];
      c.clr      = w[B_CLR];
      c.sel      = w[B_SELHI:B_SELLO];
      c.mode     = mode_e'(w[B_MODHI:B_MODLO]);
      c.ie       = w[B_IE];
      c.down     = w[B_DOWN];
      c.wide     = w[B_WIDE];
      c.rld      = w[B_RLD];
      return c;
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
   parameter int DIV_STAGES = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [DIV_STAGES:0] tick
);
   initial assert (DIV_STAGES >= 6)
      else $error("tmr_prescale: DIV_STAGES must cover divide-by-64");

   logic [DIV_STAGES-1:0] pcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) pcnt <= '0;
      else        pcnt <= pcnt + 1'b1;
   end

   assign tick[0] = 1'b1;
   for (genvar k = 1; k <= DIV_STAGES; k++) begin : g_tick
      assign tick[k] = &pcnt[k-1:0];
   end

   // divide-by-2 enable never holds two cycles in a row
   p_div2_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[1] |=> !tick[1]);
   // divide-by-4 enable is followed by three idle cycles
   p_div4_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[2] |=> !tick[2] ##1 !tick[2] ##1 !tick[2]);
endmodule

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 2)
      else $error("tmr_sync: at least two stages are required");

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core import tmr_pkg::*; #(
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctl_t             ctl,
   input  logic [CNT_W-1:0] rld_val,
   input  logic             ld,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             flag,
   output logic             hit
);
   initial assert (NARROW_W > 0 && NARROW_W < CNT_W)
      else $error("tmr_core: NARROW_W must lie below CNT_W");

   localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [CNT_W-1:0] mask, cur, nxt, tc, rld_m;
   logic             live;

   assign mask  = ctl.wide ? '1 : NARROW_MASK;
   assign cur   = cnt & mask;
   assign tc    = ctl.down ? '0 : mask;
   assign nxt   = (ctl.down ? cur - 1'b1 : cur + 1'b1) & mask;
   assign rld_m = rld_val & mask;
   assign live  = step && (cur != tc);
   assign hit   = live && (nxt == tc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ld) begin
         cnt <= rld_m;
      end else if (live) begin
         if (hit) cnt <= ctl.rld ? rld_m : tc;
         else     cnt <= nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (hit)     flag <= 1'b1;
      else if (ctl.clr) flag <= 1'b0;
   end

   p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt == ($past(rld_val) & $past(mask)));
   p_narrow_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !ctl.wide) |=> cnt[CNT_W-1:NARROW_W] == '0);
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ctl.clr) |=> flag);
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.clr && !hit) |=> !flag);
   p_no_step_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld) |=> $stable(cnt));
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair import tmr_pkg::*; #(
   parameter int CNT_W       = 32,
   parameter int NARROW_W    = 16,
   parameter int DIV_STAGES  = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl0_i,
   input  logic [CTL_W-1:0] ctl1_i,
   input  logic [CNT_W-1:0] rld0_i,
   input  logic [CNT_W-1:0] rld1_i,
   input  logic [1:0]       ld_i,
   input  logic [1:0]       ext_evt_i,
   input  logic [1:0]       ext_gate_i,
   input  logic             dbg_halt_i,
   output logic [CNT_W-1:0] cnt0_o,
   output logic [CNT_W-1:0] cnt1_o,
   output logic [1:0]       flag_o,
   output logic [1:0]       irq_o
);
   localparam int NTMR  = 2;
   localparam int NSRC  = 1 << SEL_W;

   ctl_t             c_a   [NTMR];
   logic [CNT_W-1:0] rld_a [NTMR];
   logic [CNT_W-1:0] cnt_a [NTMR];
   logic [NTMR-1:0]  hit_a, step_a, flag_a;
   logic [NTMR-1:0]  gate_l, evt_l, evt_prev, evt_rise;
   logic [DIV_STAGES:0] tick;

   assign c_a[0]   = ctl_decode(ctl0_i);
   assign c_a[1]   = ctl_decode(ctl1_i);
   assign rld_a[0] = rld0_i;
   assign rld_a[1] = rld1_i;
   assign cnt0_o   = cnt_a[0];
   assign cnt1_o   = cnt_a[1];
   assign flag_o   = flag_a;

   tmr_prescale #(.DIV_STAGES(DIV_STAGES)) u_pre (
      .clk (clk),
      .rst_n (rst_n),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) evt_prev <= '0;
      else        evt_prev <= evt_l;
   end
   assign evt_rise = evt_l & ~evt_prev;

   for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
      logic [NSRC-1:0] src;
      logic            base, chain_src, qual, halt_ok;

      tmr_sync #(.STAGES(SYNC_STAGES)) u_gsync (
         .clk (clk), .rst_n (rst_n), .d (ext_gate_i[gi]), .q (gate_l[gi])
      );
      tmr_sync #(.STAGES(SYNC_STAGES)) u_esync (
         .clk (clk), .rst_n (rst_n), .d (ext_evt_i[gi]), .q (evt_l[gi])
      );

      assign src  = {evt_rise[gi], tick[SEL_EXT-1:0]};
      assign base = src[c_a[gi].sel];

      if (gi == 1) begin : g_chain
         assign chain_src = hit_a[0];
      end else begin : g_nochain
         assign chain_src = base;
      end

      always_comb begin
         unique case (c_a[gi].mode)
            M_FREE:    qual = base;
            M_GATE_LO: qual = base & ~gate_l[gi];
            M_GATE_HI: qual = base & gate_l[gi];
            default:   qual = chain_src;
         endcase
      end

      assign halt_ok    = !(c_a[gi].dbg_stop && dbg_halt_i);
      assign step_a[gi] = c_a[gi].en && halt_ok && qual;
      assign irq_o[gi]  = flag_a[gi] & c_a[gi].ie;

      tmr_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctl     (c_a[gi]),
         .rld_val (rld_a[gi]),
         .ld      (ld_i[gi]),
         .step    (step_a[gi]),
         .cnt     (cnt_a[gi]),
         .flag    (flag_a[gi]),
         .hit     (hit_a[gi])
      );

      p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (!c_a[gi].en && !ld_i[gi]) |=> $stable(cnt_a[gi]));
      p_debug_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (c_a[gi].en && c_a[gi].dbg_stop && dbg_halt_i && !ld_i[gi]) |=> $stable(cnt_a[gi]));
      p_gate_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (c_a[gi].mode == M_GATE_HI && !gate_l[gi] && !ld_i[gi]) |=> $stable(cnt_a[gi]));
      p_hit_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
         hit_a[gi] |=> flag_o[gi]);
      p_event_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
         evt_rise[gi] |=> !evt_rise[gi]);
   end

   p_chain_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (c_a[1].mode == M_CHAIN && !hit_a[0] && !ld_i[1]) |=> $stable(cnt_a[1]));
endmodule

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctl0 = '0, ctl1 = '0;
   logic [31:0] rld0 = '0, rld1 = '0;
   logic [1:0]  ld = '0, evt = '0, gate = '0;
   logic        halt = 1'b0;
   logic [31:0] cnt0, cnt1;
   logic [1:0]  flag, irq;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   tmr_pair u0 (
      .clk (clk), .rst_n (rst_n), .ctl0_i (ctl0), .ctl1_i (ctl1),
      .rld0_i (rld0), .rld1_i (rld1), .ld_i (ld), .ext_evt_i (evt),
      .ext_gate_i (gate), .dbg_halt_i (halt), .cnt0_o (cnt0), .cnt1_o (cnt1),
      .flag_o (flag), .irq_o (irq)
   );

   typedef struct packed {
      logic [15:0] ctl;
      logic [31:0] rld;
      logic [15:0] n;
      logic        gt;
      logic        hl;
      logic [31:0] exp;
      logic        flg;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{16'h8002, 32'd100,        16'd20,  1'b0, 1'b0, 32'd120,        1'b0},
      '{16'h8046, 32'd1000,       16'd64,  1'b0, 1'b0, 32'd968,        1'b0},
      '{16'h8182, 32'd5,          16'd256, 1'b0, 1'b0, 32'd9,          1'b0},
      '{16'h80C4, 32'h0001_2345,  16'd64,  1'b0, 1'b0, 32'h0000_233D,  1'b0},
      '{16'h8001, 32'h0000_FFFA,  16'd10,  1'b0, 1'b0, 32'h0000_FFFA,  1'b1},
      '{16'h8000, 32'h0000_FFFA,  16'd10,  1'b0, 1'b0, 32'h0000_FFFF,  1'b1},
      '{16'h8006, 32'd3,          16'd10,  1'b0, 1'b0, 32'd0,          1'b1},
      '{16'h8002, 32'hFFFF_FFFD,  16'd5,   1'b0, 1'b0, 32'hFFFF_FFFF,  1'b1},
      '{16'h8022, 32'd50,         16'd12,  1'b0, 1'b0, 32'd50,         1'b0},
      '{16'h8012, 32'd50,         16'd12,  1'b0, 1'b0, 32'd62,         1'b0},
      '{16'h8022, 32'd50,         16'd12,  1'b1, 1'b0, 32'd62,         1'b0},
      '{16'h8402, 32'd50,         16'd12,  1'b0, 1'b1, 32'd50,         1'b0},
      '{16'h8002, 32'd50,         16'd12,  1'b0, 1'b1, 32'd62,         1'b0},
      '{16'h0002, 32'd50,         16'd12,  1'b0, 1'b0, 32'd50,         1'b0},
      '{16'h8032, 32'd7,          16'd6,   1'b0, 1'b0, 32'd13,         1'b0},
      '{16'h8007, 32'd2,          16'd5,   1'b0, 1'b0, 32'd1,          1'b1}
   };

   function automatic string vtag(input int i);
      case (i)
         0, 1, 2:     return "R3 prescale";
         3, 7:        return "R6 width/direction";
         4, 5, 6, 15: return "R7 terminal count";
         8, 9, 10:    return "R5 gate";
         11, 12:      return "R9 debug halt";
         13:          return "R1 disabled";
         default:     return "R11 mode3 on timer0";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      ctl0 = '0; ctl1 = '0; ld = '0; evt = '0; gate = '0; halt = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_vec(input int i);
      vec_t v;
      v = VECS[i];
      do_reset();
      gate[0] = v.gt; halt = v.hl;
      ctl0 = v.ctl & 16'h7FFF; rld0 = v.rld; ld = 2'b01;
      @(negedge clk);
      ld = 2'b00;
      repeat (4) @(negedge clk);
      ctl0 = v.ctl;
      repeat (int'(v.n)) @(negedge clk);
      ctl0 = v.ctl & 16'h7FFF;
      @(negedge clk);
      chk({vtag(i), " count"}, cnt0, v.exp);
      chk({vtag(i), " flag"}, {31'd0, flag[0]}, {31'd0, v.flg});
   endtask

   initial begin
      do_reset();
      @(negedge clk);
      chk("R12 reset cnt0", cnt0, 32'd0);
      chk("R12 reset cnt1", cnt1, 32'd0);
      chk("R12 reset flags", {30'd0, flag}, 32'd0);
      chk("R12 reset irq", {30'd0, irq}, 32'd0);

      for (int i = 0; i < NV; i++) run_vec(i);

      // load, masking, interrupt output and clear
      do_reset();
      ctl0 = 16'h0000; rld0 = 32'hABCD_1234; ld = 2'b01;
      @(negedge clk);
      ld = 2'b00;
      chk("R2 narrow load", cnt0, 32'h0000_1234);
      ctl0 = 16'h000E; rld0 = 32'd2; ld = 2'b01;
      @(negedge clk);
      ld = 2'b00;
      chk("R2 wide load", cnt0, 32'd2);
      ctl0 = 16'h800E;
      repeat (5) @(negedge clk);
      ctl0 = 16'h000E;
      @(negedge clk);
      chk("R7 down stop", cnt0, 32'd0);
      chk("R8 irq enabled", {31'd0, irq[0]}, 32'd1);
      ctl0 = 16'h0006;
      @(negedge clk);
      chk("R8 irq masked", {31'd0, irq[0]}, 32'd0);
      chk("R8 flag sticky", {31'd0, flag[0]}, 32'd1);
      ctl0 = 16'h0206;
      @(negedge clk);
      ctl0 = 16'h0006;
      @(negedge clk);
      chk("R8 flag cleared", {31'd0, flag[0]}, 32'd0);

      // external events
      do_reset();
      ctl0 = 16'h01C2; rld0 = 32'd10; ld = 2'b01;
      @(negedge clk);
      ld = 2'b00;
      ctl0 = 16'h81C2;
      for (int e = 0; e < 5; e++) begin
         evt[0] = 1'b1;
         repeat (2) @(negedge clk);
         evt[0] = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk("R4 event count", cnt0, 32'd15);
      ctl0 = 16'h01C2;
      @(negedge clk);
      evt[0] = 1'b1;
      repeat (3) @(negedge clk);
      evt[0] = 1'b0;
      repeat (6) @(negedge clk);
      chk("R1 event while disabled", cnt0, 32'd15);

      // chaining
      do_reset();
      ctl0 = 16'h0001; rld0 = 32'h0000_FFFD;
      ctl1 = 16'h0032; rld1 = 32'd0; ld = 2'b11;
      @(negedge clk);
      ld = 2'b00;
      ctl0 = 16'h8001; ctl1 = 16'h8032;
      repeat (9) @(negedge clk);
      ctl0 = 16'h0001; ctl1 = 16'h0032;
      @(negedge clk);
      chk("R10 chain lower", cnt0, 32'h0000_FFFE);
      chk("R10 chain upper", cnt1, 32'd4);
      ctl1 = 16'h8032;
      repeat (5) @(negedge clk);
      ctl1 = 16'h0032;
      @(negedge clk);
      chk("R10 upper idle without lower hits", cnt1, 32'd4);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R12 act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule